// File: doc/BRIEF.md
# Asynchronous Serial Transceiver with Power and Enable Sequencing

This block is a full-duplex asynchronous serial port for a peripheral subsystem. A master power input gates the whole port: while it is low, the transmit and receive state machines, the enable synchronizers, the receive buffer and the error flags are all held in reset. When power is high, separate transmit and receive enable inputs take effect. Each enable first passes through a two-stage synchronizer that advances only on the base clock, a tick produced by a plain divider from the system clock. One serial bit lasts `OVS` base-clock ticks.

The transmitter sends a start bit, then 7 or 8 data bits with the least significant bit first, then an optional parity bit, then one or two stop bits. At the end of the frame it pulses a completion output. The receiver brings the line in through a two-flop synchronizer. It confirms a start bit at mid-bit and samples every later bit at mid-bit. It always checks exactly one stop bit. A received character goes into a one-entry buffer. A character that completes while the buffer is still full is discarded and flagged as an overrun. Parity, framing and overrun flags are sticky and are cleared by a status-read strobe.

Top module: `uart_xcvr`

## Requirements
- R1: While `pwr` is 0, `txd` is 1, `tx_done`, `rx_irq`, `rx_full` and all error flags are 0, and the enables and `tx_wr` have no effect.
- R2: An enable takes effect only through its base-clock synchronizer. Clearing `tx_en` for at least two base-clock ticks aborts a frame in progress: `txd` returns to 1 and no `tx_done` follows.
- R3: A transmitted frame consists of a start bit of 0, then `char8 ? 8 : 7` data bits LSB first, then the parity bit if one is selected, then one stop bit of 1 (two when `stop2` is 1). Each bit lasts `OVS` ticks. `tx_done` pulses for one cycle after the last stop bit.
- R4: The `par_mode` encoding is 00 no parity bit, 01 parity bit always 0, 10 odd parity, 11 even parity. Parity covers only the active data bits.
- R5: A `tx_wr` that arrives while a frame is in progress is ignored. Only the first byte goes out.
- R6: When the receiver completes a character and the buffer is empty, it stores the character (upper bit 0 in 7-bit mode), sets `rx_full` and pulses `rx_irq`. A `rx_rd` strobe clears `rx_full`.
- R7: With `par_mode` 10 or 11, a parity bit that disagrees with the data sets `err_parity`. With modes 00 and 01 the parity bit is never checked.
- R8: The receiver checks only the first bit after the data or parity bits. If it is 0, `err_frame` is set. The `stop2` setting has no effect on reception.
- R9: If a character completes while `rx_full` is 1 and no `rx_rd` arrives in that cycle, the character is discarded, `rx_data` keeps its old value and `err_overrun` is set.
- R10: A `st_rd` strobe clears all three error flags. An error that is detected in the same cycle as the strobe still sets its flag.
- R11: If reception is enabled while `rxd` is already low, that low level is taken as a start bit and a character is received.
- R12: `rx_err_irq` pulses for one cycle whenever a completed character carries a parity, framing or overrun error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr | input | 1 | Master power; 0 holds the port in reset |
| tx_en | input | 1 | Transmit enable (raw, synchronized inside) |
| rx_en | input | 1 | Receive enable (raw, synchronized inside) |
| par_mode | input | 2 | Parity mode: 00 none, 01 zero, 10 odd, 11 even |
| char8 | input | 1 | 1 for 8 data bits, 0 for 7 |
| stop2 | input | 1 | 1 for two transmitted stop bits |
| tx_wr | input | 1 | Load strobe for transmit data |
| tx_data | input | 8 | Byte to transmit |
| tx_done | output | 1 | One-cycle pulse when a frame has been sent |
| txd | output | 1 | Serial output, idle high |
| rxd | input | 1 | Serial input, asynchronous |
| rx_rd | input | 1 | Receive buffer read strobe |
| rx_data | output | 8 | Receive buffer contents |
| rx_full | output | 1 | Receive buffer holds unread data |
| rx_irq | output | 1 | One-cycle pulse when a character is stored |
| st_rd | input | 1 | Status read strobe; clears error flags |
| err_parity | output | 1 | Sticky parity error |
| err_frame | output | 1 | Sticky framing error |
| err_overrun | output | 1 | Sticky overrun error |
| rx_err_irq | output | 1 | One-cycle pulse when a character carries an error |

## Verification
Two receive events can fall in the same cycle as the status-read clear. One is the detection of a bad stop bit; the other is the discard of a character because of overrun. The bench provokes the first case by holding `st_rd` high for the whole of a frame that has a low stop bit. It judges the result at the cycle where `rx_err_irq` is high. There `err_frame` must read 1, because the set must win. It must read 0 once the strobe has acted again. The buffer-read strobe can also coincide with a completing character. The overrun checks therefore drive `rx_rd` low throughout and then confirm that the old byte is kept.

// File: rtl/uart_pkg.sv
package uart_pkg;

    typedef enum logic [1:0] {
        PAR_NONE = 2'b00,
        PAR_ZERO = 2'b01,
        PAR_ODD  = 2'b10,
        PAR_EVEN = 2'b11
    } par_e;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_START,
        PH_DATA,
        PH_PAR,
        PH_STOP
    } phase_e;

    // Parity bit for the active data bits under the given mode
    function automatic logic par_gen(input logic [7:0] d, input logic c8, input par_e m);
        logic x;
        x = ^(c8 ? d : {1'b0, d[6:0]});
        case (m)
            PAR_ODD:  return ~x;
            PAR_EVEN: return x;
            default:  return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/uart_baud.sv
module uart_baud #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          tick;
    } st_t;

    st_t d, q;

    always_comb begin
        d = q;
        if (q.cnt == CW'(DIV - 1)) begin
            d.cnt  = '0;
            d.tick = 1'b1;
        end else begin
            d.cnt  = q.cnt + 1'b1;
            d.tick = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign tick = q.tick;
endmodule

// File: rtl/uart_ensync.sv
module uart_ensync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic en_in,
    output logic en_out
);
    typedef struct packed {
        logic [STAGES-1:0] sh;
    } st_t;

    st_t d, q;

    always_comb begin
        d = q;
        if (tick) d.sh = {q.sh[STAGES-2:0], en_in};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign en_out = q.sh[STAGES-1];
endmodule

// File: rtl/uart_tx.sv
module uart_tx
    import uart_pkg::*;
#(
    parameter int OVS = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       en,
    input  logic       wr,
    input  logic [7:0] wdata,
    input  par_e       pmode,
    input  logic       c8,
    input  logic       stop2,
    output logic       txd,
    output logic       done
);
    localparam int SW = $clog2(OVS);

    typedef struct packed {
        phase_e        ph;
        logic [SW-1:0] sub;
        logic [2:0]    bitn;
        logic [7:0]    sh;
        logic          pbit;
        logic          extra;
        logic          done;
    } st_t;

    st_t d, q;

    always_comb begin
        d      = q;
        d.done = 1'b0;
        if (!en) begin
            d.ph  = PH_IDLE;
            d.sub = '0;
        end else begin
            case (q.ph)
                PH_IDLE: begin
                    if (wr) begin
                        d.ph    = PH_START;
                        d.sub   = '0;
                        d.bitn  = '0;
                        d.sh    = wdata;
                        d.pbit  = par_gen(wdata, c8, pmode);
                        d.extra = stop2;
                    end
                end
                default: begin
                    if (tick) begin
                        if (q.sub == SW'(OVS - 1)) begin
                            d.sub = '0;
                            case (q.ph)
                                PH_START: begin
                                    d.ph   = PH_DATA;
                                    d.bitn = '0;
                                end
                                PH_DATA: begin
                                    d.sh   = q.sh >> 1;
                                    d.bitn = q.bitn + 3'd1;
                                    if (q.bitn == (c8 ? 3'd7 : 3'd6))
                                        d.ph = (pmode == PAR_NONE) ? PH_STOP : PH_PAR;
                                end
                                PH_PAR: d.ph = PH_STOP;
                                PH_STOP: begin
                                    if (q.extra) begin
                                        d.extra = 1'b0;
                                    end else begin
                                        d.ph   = PH_IDLE;
                                        d.done = 1'b1;
                                    end
                                end
                                default: d.ph = PH_IDLE;
                            endcase
                        end else begin
                            d.sub = q.sub + 1'b1;
                        end
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        case (q.ph)
            PH_START: txd = 1'b0;
            PH_DATA:  txd = q.sh[0];
            PH_PAR:   txd = q.pbit;
            default:  txd = 1'b1;
        endcase
    end

    assign done = q.done;
endmodule

// File: rtl/uart_rx.sv
module uart_rx
    import uart_pkg::*;
#(
    parameter int OVS = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       en,
    input  logic       rxd,
    input  par_e       pmode,
    input  logic       c8,
    input  logic       rd,
    input  logic       st_rd,
    output logic [7:0] rdata,
    output logic       full,
    output logic       perr,
    output logic       ferr,
    output logic       oerr,
    output logic       irq,
    output logic       eirq
);
    localparam int SW = $clog2(OVS);

    typedef struct packed {
        logic          s1;
        logic          s2;
        phase_e        ph;
        logic [SW-1:0] sub;
        logic [2:0]    bitn;
        logic [7:0]    sh;
        logic          pbit;
        logic [7:0]    rbuf;
        logic          full;
        logic          perr;
        logic          ferr;
        logic          oerr;
        logic          irq;
        logic          eirq;
    } st_t;

    st_t d, q;

    logic       line;
    logic [7:0] data_al;
    logic       par_bad;
    logic       bit_end;

    assign line    = q.s2;
    assign data_al = c8 ? q.sh : {1'b0, q.sh[7:1]};
    assign bit_end = (q.sub == SW'(OVS - 1));

    always_comb begin
        case (pmode)
            PAR_ODD:  par_bad = ~(^data_al ^ q.pbit);
            PAR_EVEN: par_bad = ^data_al ^ q.pbit;
            default:  par_bad = 1'b0;
        endcase
    end

    always_comb begin
        d      = q;
        d.irq  = 1'b0;
        d.eirq = 1'b0;
        d.s1   = rxd;
        d.s2   = q.s1;
        // clears first, so a same-cycle set below wins
        if (rd) d.full = 1'b0;
        if (st_rd) begin
            d.perr = 1'b0;
            d.ferr = 1'b0;
            d.oerr = 1'b0;
        end
        if (!en) begin
            d.ph  = PH_IDLE;
            d.sub = '0;
        end else if (tick) begin
            case (q.ph)
                PH_IDLE: begin
                    if (!line) begin
                        d.ph  = PH_START;
                        d.sub = '0;
                    end
                end
                PH_START: begin
                    if (q.sub == SW'(OVS / 2 - 1)) begin
                        d.sub  = '0;
                        d.bitn = '0;
                        d.ph   = line ? PH_IDLE : PH_DATA;
                    end else begin
                        d.sub = q.sub + 1'b1;
                    end
                end
                PH_DATA: begin
                    if (bit_end) begin
                        d.sub  = '0;
                        d.sh   = {line, q.sh[7:1]};
                        d.bitn = q.bitn + 3'd1;
                        if (q.bitn == (c8 ? 3'd7 : 3'd6))
                            d.ph = (pmode == PAR_NONE) ? PH_STOP : PH_PAR;
                    end else begin
                        d.sub = q.sub + 1'b1;
                    end
                end
                PH_PAR: begin
                    if (bit_end) begin
                        d.sub  = '0;
                        d.pbit = line;
                        d.ph   = PH_STOP;
                    end else begin
                        d.sub = q.sub + 1'b1;
                    end
                end
                PH_STOP: begin
                    if (bit_end) begin
                        d.sub = '0;
                        d.ph  = PH_IDLE;
                        if (q.full && !rd) begin
                            d.oerr = 1'b1;
                            d.eirq = 1'b1;
                        end else begin
                            d.rbuf = data_al;
                            d.full = 1'b1;
                            d.irq  = 1'b1;
                            if (par_bad) d.perr = 1'b1;
                            if (!line)   d.ferr = 1'b1;
                            d.eirq = par_bad | ~line;
                        end
                    end else begin
                        d.sub = q.sub + 1'b1;
                    end
                end
                default: d.ph = PH_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q    <= '0;
            q.s1 <= 1'b1;
            q.s2 <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign rdata = q.rbuf;
    assign full  = q.full;
    assign perr  = q.perr;
    assign ferr  = q.ferr;
    assign oerr  = q.oerr;
    assign irq   = q.irq;
    assign eirq  = q.eirq;
endmodule

// File: rtl/uart_xcvr.sv
module uart_xcvr
    import uart_pkg::*;
#(
    parameter int CLK_DIV = 4,
    parameter int OVS     = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pwr,
    input  logic       tx_en,
    input  logic       rx_en,
    input  logic [1:0] par_mode,
    input  logic       char8,
    input  logic       stop2,
    input  logic       tx_wr,
    input  logic [7:0] tx_data,
    output logic       tx_done,
    output logic       txd,
    input  logic       rxd,
    input  logic       rx_rd,
    output logic [7:0] rx_data,
    output logic       rx_full,
    output logic       rx_irq,
    input  logic       st_rd,
    output logic       err_parity,
    output logic       err_frame,
    output logic       err_overrun,
    output logic       rx_err_irq
);
    localparam int NEN   = 2;
    localparam int EN_TX = 0;
    localparam int EN_RX = 1;

    logic           tick;
    logic           core_rst_n;
    logic [NEN-1:0] en_raw;
    logic [NEN-1:0] en_eff;
    par_e           pm;

    assign core_rst_n = rst_n & pwr;
    assign en_raw     = {rx_en, tx_en};
    assign pm         = par_e'(par_mode);

    uart_baud #(.DIV(CLK_DIV)) u_baud (
        .clk  (clk),
        .rst_n(rst_n),
        .tick (tick)
    );

    for (genvar g = 0; g < NEN; g++) begin : g_ensync
        uart_ensync #(.STAGES(2)) u_sync (
            .clk   (clk),
            .rst_n (core_rst_n),
            .tick  (tick),
            .en_in (en_raw[g]),
            .en_out(en_eff[g])
        );
    end

    uart_tx #(.OVS(OVS)) u_tx (
        .clk  (clk),
        .rst_n(core_rst_n),
        .tick (tick),
        .en   (en_eff[EN_TX]),
        .wr   (tx_wr),
        .wdata(tx_data),
        .pmode(pm),
        .c8   (char8),
        .stop2(stop2),
        .txd  (txd),
        .done (tx_done)
    );

    uart_rx #(.OVS(OVS)) u_rx (
        .clk  (clk),
        .rst_n(core_rst_n),
        .tick (tick),
        .en   (en_eff[EN_RX]),
        .rxd  (rxd),
        .pmode(pm),
        .c8   (char8),
        .rd   (rx_rd),
        .st_rd(st_rd),
        .rdata(rx_data),
        .full (rx_full),
        .perr (err_parity),
        .ferr (err_frame),
        .oerr (err_overrun),
        .irq  (rx_irq),
        .eirq (rx_err_irq)
    );
endmodule

// File: rtl/uart_xcvr_chk.sv
module uart_xcvr_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       pwr,
    input logic       tx_done,
    input logic       txd,
    input logic       rx_rd,
    input logic [7:0] rx_data,
    input logic       rx_full,
    input logic       rx_irq,
    input logic       st_rd,
    input logic       err_parity,
    input logic       err_frame,
    input logic       err_overrun,
    input logic       rx_err_irq
);
    // R1: powered-down port is silent and empty
    p_pwr_off_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr |-> (txd && !tx_done && !rx_irq && !rx_full && !rx_err_irq));

    // R3: completion is a single-cycle pulse
    p_done_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        tx_done |=> !tx_done);

    // R6: a stored character leaves the buffer full
    p_irq_full_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rx_irq |-> rx_full);

    // R9: an unread buffer is never overwritten
    p_keep_unread_r9: assert property (@(posedge clk) disable iff (!rst_n || !pwr)
        (rx_full && !rx_rd) |=> (rx_full && $stable(rx_data)));

    // R10: after a status read only a fresh error can leave a flag set
    p_status_clear_r10: assert property (@(posedge clk) disable iff (!rst_n || !pwr)
        st_rd |=> (rx_err_irq || !(err_parity || err_frame || err_overrun)));

    // R12: an error pulse always comes with a flag
    p_err_irq_flag_r12: assert property (@(posedge clk) disable iff (!rst_n)
        rx_err_irq |-> (err_parity || err_frame || err_overrun));
endmodule

bind uart_xcvr uart_xcvr_chk i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .pwr        (pwr),
    .tx_done    (tx_done),
    .txd        (txd),
    .rx_rd      (rx_rd),
    .rx_data    (rx_data),
    .rx_full    (rx_full),
    .rx_irq     (rx_irq),
    .st_rd      (st_rd),
    .err_parity (err_parity),
    .err_frame  (err_frame),
    .err_overrun(err_overrun),
    .rx_err_irq (rx_err_irq)
);

// File: tb/test_uart_xcvr.sv
module test_uart_xcvr;
    localparam int BIT = 32;   // CLK_DIV 2 x OVS 16

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pwr = 1'b0, tx_en = 1'b0, rx_en = 1'b0;
    logic [1:0] par_mode = 2'b00;
    logic       char8 = 1'b1, stop2 = 1'b0;
    logic       tx_wr = 1'b0;
    logic [7:0] tx_data = 8'h00;
    logic       tx_done, txd;
    logic       rxd = 1'b1;
    logic       rx_rd = 1'b0, st_rd = 1'b0;
    logic [7:0] rx_data;
    logic       rx_full, rx_irq, err_parity, err_frame, err_overrun, rx_err_irq;

    int checks = 0;
    int errors = 0;
    int done_cnt = 0, irq_cnt = 0, eirq_cnt = 0;
    logic ferr_at_eirq = 1'b0;

    always #4 clk = ~clk;

    uart_xcvr #(.CLK_DIV(2), .OVS(16)) i_uart_xcvr (
        .clk(clk), .rst_n(rst_n), .pwr(pwr), .tx_en(tx_en), .rx_en(rx_en),
        .par_mode(par_mode), .char8(char8), .stop2(stop2), .tx_wr(tx_wr),
        .tx_data(tx_data), .tx_done(tx_done), .txd(txd), .rxd(rxd), .rx_rd(rx_rd),
        .rx_data(rx_data), .rx_full(rx_full), .rx_irq(rx_irq), .st_rd(st_rd),
        .err_parity(err_parity), .err_frame(err_frame), .err_overrun(err_overrun),
        .rx_err_irq(rx_err_irq)
    );

    always @(negedge clk) begin
        if (tx_done)    done_cnt++;
        if (rx_irq)     irq_cnt++;
        if (rx_err_irq) begin
            eirq_cnt++;
            ferr_at_eirq = err_frame;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic config_link(input logic [1:0] pm, input logic c8, input logic s2,
                               input logic te, input logic re);
        @(negedge clk);
        tx_en = 1'b0; rx_en = 1'b0;
        wait_clk(8);
        par_mode = pm; char8 = c8; stop2 = s2;
        wait_clk(2);
        tx_en = te; rx_en = re;
        wait_clk(10);
    endtask

    task automatic tx_write(input logic [7:0] v);
        @(negedge clk);
        tx_data = v; tx_wr = 1'b1;
        @(negedge clk);
        tx_wr = 1'b0;
    endtask

    task automatic tx_capture(input int nb, output logic [11:0] fr);
        int t = 0;
        fr = '1;
        while (txd !== 1'b0 && t < 300) begin
            @(negedge clk);
            t++;
        end
        if (t >= 300) begin
            chk(1'b0, "R3 start bit missing", txd, 0);
            return;
        end
        wait_clk(BIT / 2);
        for (int i = 0; i < nb; i++) begin
            fr[i] = txd;
            if (i < nb - 1) wait_clk(BIT);
        end
    endtask

    function automatic logic bench_par(input logic [7:0] v, input logic c8, input logic [1:0] pm);
        logic x;
        x = ^(c8 ? v : {1'b0, v[6:0]});
        case (pm)
            2'b10:   return ~x;
            2'b11:   return x;
            default: return 1'b0;
        endcase
    endfunction

    task automatic rx_frame(input logic [7:0] v, input logic c8, input logic [1:0] pm,
                            input bit bad_par, input bit bad_stop);
        int n;
        n = c8 ? 8 : 7;
        @(negedge clk);
        rxd = 1'b0; wait_clk(BIT);
        for (int i = 0; i < n; i++) begin
            rxd = v[i]; wait_clk(BIT);
        end
        if (pm != 2'b00) begin
            rxd = bench_par(v, c8, pm) ^ bad_par; wait_clk(BIT);
        end
        if (bad_stop) begin
            rxd = 1'b0; wait_clk(24);
            rxd = 1'b1; wait_clk(8);
        end else begin
            rxd = 1'b1; wait_clk(BIT);
        end
        rxd = 1'b1; wait_clk(BIT);
    endtask

    task automatic drain_rx;
        @(negedge clk); rx_rd = 1'b1; st_rd = 1'b1;
        @(negedge clk); rx_rd = 1'b0; st_rd = 1'b0;
        wait_clk(1);
    endtask

    task automatic t_reset;
        chk(txd == 1'b1, "R1 reset txd", txd, 1);
        chk(rx_full == 1'b0 && err_parity == 1'b0 && err_frame == 1'b0 && err_overrun == 1'b0,
            "R1 reset flags", {rx_full, err_parity, err_frame, err_overrun}, 0);
    endtask

    task automatic t_power_gate;
        int lows = 0;
        int d0 = done_cnt;
        tx_en = 1'b1; rx_en = 1'b1;
        tx_write(8'h00);
        rxd = 1'b0;
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            if (txd == 1'b0) lows++;
        end
        rxd = 1'b1;
        wait_clk(4);
        chk(lows == 0, "R1 txd stays idle without power", lows, 0);
        chk(rx_full == 1'b0 && done_cnt == d0, "R1 no receive or done without power",
            {rx_full, done_cnt - d0}, 0);
        tx_en = 1'b0; rx_en = 1'b0;
        @(negedge clk); pwr = 1'b1;
        wait_clk(4);
    endtask

    task automatic t_tx_8n1;
        logic [11:0] fr;
        int d0, lows;
        config_link(2'b00, 1'b1, 1'b0, 1'b1, 1'b0);
        d0 = done_cnt;
        tx_write(8'hA5);
        fork
            tx_capture(10, fr);
            begin wait_clk(100); tx_write(8'h3C); end
        join
        chk(fr[0] == 1'b0, "R3 start bit 0", fr[0], 0);
        chk(fr[8:1] == 8'hA5, "R3 data LSB first", fr[8:1], 8'hA5);
        chk(fr[9] == 1'b1, "R3 stop bit 1", fr[9], 1);
        wait_clk(BIT);
        chk(done_cnt - d0 == 1, "R3 one done pulse", done_cnt - d0, 1);
        lows = 0;
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            if (txd == 1'b0) lows++;
        end
        chk(lows == 0 && done_cnt - d0 == 1, "R5 write while busy ignored", lows, 0);
    endtask

    task automatic t_tx_7o2;
        logic [11:0] fr;
        int d0;
        config_link(2'b10, 1'b0, 1'b1, 1'b1, 1'b0);
        d0 = done_cnt;
        tx_write(8'h53);
        tx_capture(11, fr);
        chk(fr[7:1] == 7'h53, "R3 seven data bits", fr[7:1], 7'h53);
        chk(fr[8] == 1'b1, "R4 odd parity bit", fr[8], 1);
        chk(fr[10:9] == 2'b11 && done_cnt == d0, "R3 two stop bits before done",
            {fr[10:9], done_cnt - d0}, 3'b110);
        wait_clk(BIT);
        chk(done_cnt - d0 == 1, "R3 done after second stop", done_cnt - d0, 1);
    endtask

    task automatic t_tx_parity_modes;
        logic [11:0] fr;
        config_link(2'b01, 1'b1, 1'b0, 1'b1, 1'b0);
        tx_write(8'hFF);
        tx_capture(11, fr);
        chk(fr[9] == 1'b0 && fr[10] == 1'b1, "R4 zero parity bit", fr[10:9], 2'b10);
        wait_clk(BIT);
        config_link(2'b11, 1'b1, 1'b0, 1'b1, 1'b0);
        tx_write(8'h07);
        tx_capture(11, fr);
        chk(fr[9] == 1'b1, "R4 even parity bit", fr[9], 1);
        wait_clk(BIT);
    endtask

    task automatic t_tx_abort;
        int d0;
        config_link(2'b00, 1'b1, 1'b0, 1'b1, 1'b0);
        d0 = done_cnt;
        tx_write(8'h00);
        wait_clk(80);
        chk(txd == 1'b0, "R2 frame running before abort", txd, 0);
        tx_en = 1'b0;
        wait_clk(10);
        chk(txd == 1'b1, "R2 abort returns line high", txd, 1);
        tx_en = 1'b1;
        wait_clk(400);
        chk(done_cnt == d0 && txd == 1'b1, "R2 aborted frame gives no done", done_cnt - d0, 0);
    endtask

    task automatic t_rx_basic;
        int i0;
        config_link(2'b00, 1'b1, 1'b0, 1'b0, 1'b1);
        drain_rx();
        i0 = irq_cnt;
        rx_frame(8'h3C, 1'b1, 2'b00, 1'b0, 1'b0);
        chk(rx_full == 1'b1 && rx_data == 8'h3C, "R6 byte stored", rx_data, 8'h3C);
        chk(irq_cnt - i0 == 1, "R6 receive pulse", irq_cnt - i0, 1);
        chk({err_parity, err_frame, err_overrun} == 3'b000, "R6 no error",
            {err_parity, err_frame, err_overrun}, 0);
        drain_rx();
        chk(rx_full == 1'b0, "R6 read empties buffer", rx_full, 0);
    endtask

    task automatic t_rx_parity;
        config_link(2'b11, 1'b1, 1'b0, 1'b0, 1'b1);
        drain_rx();
        rx_frame(8'h81, 1'b1, 2'b11, 1'b0, 1'b0);
        chk(err_parity == 1'b0 && rx_data == 8'h81, "R7 good even parity", err_parity, 0);
        drain_rx();
        rx_frame(8'h81, 1'b1, 2'b11, 1'b1, 1'b0);
        chk(err_parity == 1'b1, "R7 bad even parity flagged", err_parity, 1);
        drain_rx();
        chk(err_parity == 1'b0, "R10 status read clears", err_parity, 0);
        config_link(2'b01, 1'b0, 1'b0, 1'b0, 1'b1);
        rx_frame(8'h2A, 1'b0, 2'b01, 1'b1, 1'b0);
        chk(err_parity == 1'b0 && rx_data == 8'h2A, "R7 zero mode not checked",
            {err_parity, rx_data}, 9'h02A);
        drain_rx();
    endtask

    task automatic t_rx_frame_err;
        int e0;
        config_link(2'b00, 1'b1, 1'b1, 1'b0, 1'b1);
        drain_rx();
        rx_frame(8'h55, 1'b1, 2'b00, 1'b0, 1'b0);
        chk(err_frame == 1'b0 && rx_data == 8'h55, "R8 one stop bit accepted with stop2 set",
            err_frame, 0);
        drain_rx();
        e0 = eirq_cnt;
        rx_frame(8'h66, 1'b1, 2'b00, 1'b0, 1'b1);
        chk(err_frame == 1'b1, "R8 low stop bit flagged", err_frame, 1);
        chk(eirq_cnt - e0 == 1, "R12 error pulse", eirq_cnt - e0, 1);
        chk(rx_full == 1'b0 || rx_data == 8'h66, "R8 no false restart", rx_data, 8'h66);
        drain_rx();
    endtask

    task automatic t_overrun;
        int i0, e0;
        config_link(2'b00, 1'b1, 1'b0, 1'b0, 1'b1);
        drain_rx();
        i0 = irq_cnt; e0 = eirq_cnt;
        rx_frame(8'h11, 1'b1, 2'b00, 1'b0, 1'b0);
        rx_frame(8'h22, 1'b1, 2'b00, 1'b0, 1'b0);
        chk(rx_data == 8'h11, "R9 old byte kept", rx_data, 8'h11);
        chk(err_overrun == 1'b1, "R9 overrun flag", err_overrun, 1);
        chk(irq_cnt - i0 == 1 && eirq_cnt - e0 == 1, "R12 overrun pulses",
            {irq_cnt - i0, eirq_cnt - e0}, 2'b11);
        drain_rx();
    endtask

    task automatic t_same_cycle;
        int e0;
        config_link(2'b00, 1'b1, 1'b0, 1'b0, 1'b1);
        drain_rx();
        e0 = eirq_cnt;
        ferr_at_eirq = 1'b0;
        @(negedge clk); st_rd = 1'b1;
        rx_frame(8'h0F, 1'b1, 2'b00, 1'b0, 1'b1);
        chk(eirq_cnt - e0 == 1 && ferr_at_eirq == 1'b1, "R10 set wins over same-cycle clear",
            ferr_at_eirq, 1);
        chk(err_frame == 1'b0, "R10 held read clears afterwards", err_frame, 0);
        @(negedge clk); st_rd = 1'b0;
        drain_rx();
    endtask

    task automatic t_low_start;
        config_link(2'b00, 1'b1, 1'b0, 1'b0, 1'b0);
        drain_rx();
        rxd = 1'b0;
        wait_clk(4);
        rx_en = 1'b1;
        wait_clk(292);
        rxd = 1'b1;
        wait_clk(64);
        chk(rx_full == 1'b1 && rx_data == 8'h00 && err_frame == 1'b0,
            "R11 low line at enable starts reception", {rx_full, rx_data, err_frame}, 10'h200);
        drain_rx();
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        wait_clk(4);
        t_reset();
        t_power_gate();
        t_tx_8n1();
        t_tx_7o2();
        t_tx_parity_modes();
        t_tx_abort();
        t_rx_basic();
        t_rx_parity();
        t_rx_frame_err();
        t_overrun();
        t_same_cycle();
        t_low_start();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule